// File: doc/BRIEF.md
# General-Purpose I/O Port Register Bank

This block controls one port of sixteen general-purpose pins behind a 32-bit register port. Software programs each pin's mode, driver type, edge speed, pull resistor and alternate-function index through packed configuration words; the block turns those words into per-pin pad-control outputs. Output levels can be written as a whole word or changed pin by pin through a write-only set/clear word, so one store can raise some pins and lower others without a read-modify-write.

Pin levels are brought into the clock domain by a two-stage synchronizer and read back through the input data word. A per-pin secure-attribute word is kept for the surrounding access-control logic. The register port is a plain single-cycle strobe: a write is taken on the rising clock edge where `bus_wr_en` is high, and `bus_rdata` reflects the addressed word combinationally. There is no back-pressure at this port; every access completes in the cycle it is presented, so the block never stalls its master.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset the mode word (offset 0x00) reads 0xFFFFFFFF (every pin analog, code 11) and every other word reads zero, and the pad outputs show the same values.
- R2: Mode (0x00), speed (0x08) and pull (0x0C) hold 2 bits per pin at bit 2*pin; mode codes are 00 input, 01 output, 10 alternate, 11 analog; each word reads back as written and drives `pad_mode`, `pad_speed` and `pad_pull` bit for bit.
- R3: The driver-type word (0x04) holds one bit per pin at bit pin, 1 for open-drain and 0 for push-pull, drives `pad_od_en`, and its bits 31:16 read zero.
- R4: Alternate-function indices are 4 bits per pin: pins 0 to 7 in the word at 0x20 at bit 4*pin, pins 8 to 15 in the word at 0x24 at bit 4*(pin-8); `pad_afsel[4*pin+3:4*pin]` carries the index of each pin.
- R5: A write to the set/clear word (0x18) with bit n set drives pin n's output high and with bit n+16 set drives it low; pins with neither bit keep their level, and a pin with both bits set goes high.
- R6: The set/clear word always reads zero and a write to it changes nothing but the output data word.
- R7: The output data word (0x14) takes bits 15:0 of a direct write, reads them back with bits 31:16 zero, and drives `pad_out`.
- R8: The input data word (0x10) returns `pad_in` in bits 15:0 after two rising edges (not after one), reads zero in bits 31:16, and ignores writes.
- R9: The secure-attribute word (0x30) holds one bit per pin at bit pin, reads back as written, and reads zero in bits 31:16.
- R10: Reads of any other offset return zero and writes to them change no register and no pad output.
- R11: A written value appears on the pad outputs directly after the rising edge that takes the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte offset of the accessed word |
| bus_wr_en | input | 1 | Write strobe, taken on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 16 | Asynchronous pin levels |
| pad_mode | output | 32 | Mode code per pin, 2 bits each |
| pad_out | output | 16 | Output level per pin |
| pad_od_en | output | 16 | Open-drain enable per pin |
| pad_pull | output | 32 | Pull selection per pin, 2 bits each |
| pad_speed | output | 32 | Speed code per pin, 2 bits each |
| pad_afsel | output | 64 | Alternate-function index per pin, 4 bits each |

## Verification
A wrong stored configuration bit shows up at the pad outputs on the very next cycle after the write, and on `bus_rdata` as soon as the word is addressed, since reads are combinational. A set/clear priority or masking fault shows as a wrong `pad_out` level one edge after the set/clear store, on exactly the pins whose bits were touched or left alone. A synchronizer of the wrong depth shows as the input word changing one edge early or late after a `pad_in` step.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    PM_INPUT  = 2'b00,
    PM_OUTPUT = 2'b01,
    PM_ALT    = 2'b10,
    PM_ANALOG = 2'b11
  } pin_mode_e;

  localparam int unsigned OFS_MODE  = 'h00;
  localparam int unsigned OFS_DRV   = 'h04;
  localparam int unsigned OFS_SPEED = 'h08;
  localparam int unsigned OFS_PULL  = 'h0C;
  localparam int unsigned OFS_IN    = 'h10;
  localparam int unsigned OFS_OUT   = 'h14;
  localparam int unsigned OFS_SETCL = 'h18;
  localparam int unsigned OFS_AF_LO = 'h20;
  localparam int unsigned OFS_AF_HI = 'h24;
  localparam int unsigned OFS_SEC   = 'h30;

endpackage

// File: rtl/gpio_cfg_word.sv
module gpio_cfg_word #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else if (we) q <= wdata;
  end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end

  // cycles since reset, saturating at 2, so the depth check never looks before reset
  logic [1:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  assert_sync_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm == 2'd2) |-> (dout == $past(din, 2)));

endmodule

// File: rtl/gpio_out_data.sv
module gpio_out_data #(
  parameter int unsigned NPINS = 16,
  parameter int unsigned DW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_word,
  input  logic             we_setcl,
  input  logic [DW-1:0]    wdata,
  output logic [NPINS-1:0] level
);

  logic [NPINS-1:0] set_m, clr_m;
  assign set_m = wdata[NPINS-1:0];
  assign clr_m = wdata[NPINS +: NPINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= '0;
    else if (we_word) level <= wdata[NPINS-1:0];
    else if (we_setcl) level <= (level & ~clr_m) | set_m;
  end

  assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we_setcl |=> ((level & $past(set_m)) == $past(set_m)));

  assert_clear_lowers_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we_setcl |=> ((level & $past(clr_m & ~set_m)) == '0));

  assert_untouched_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we_setcl |=> ((level & ~$past(set_m | clr_m)) == ($past(level) & ~$past(set_m | clr_m))));

  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_word || we_setcl) |=> $stable(level));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned NPINS = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr_en,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [NPINS-1:0]   pad_in,
  output logic [2*NPINS-1:0] pad_mode,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_od_en,
  output logic [2*NPINS-1:0] pad_pull,
  output logic [2*NPINS-1:0] pad_speed,
  output logic [4*NPINS-1:0] pad_afsel
);

  localparam int unsigned FW2     = 2 * NPINS;
  localparam int unsigned AFW     = 4 * NPINS;
  localparam int unsigned AF_LO_W = DW;
  localparam int unsigned AF_HI_W = AFW - DW;

  logic sel_mode, sel_drv, sel_speed, sel_pull, sel_in, sel_out;
  logic sel_setcl, sel_aflo, sel_afhi, sel_sec;

  assign sel_mode  = bus_addr == AW'(OFS_MODE);
  assign sel_drv   = bus_addr == AW'(OFS_DRV);
  assign sel_speed = bus_addr == AW'(OFS_SPEED);
  assign sel_pull  = bus_addr == AW'(OFS_PULL);
  assign sel_in    = bus_addr == AW'(OFS_IN);
  assign sel_out   = bus_addr == AW'(OFS_OUT);
  assign sel_setcl = bus_addr == AW'(OFS_SETCL);
  assign sel_aflo  = bus_addr == AW'(OFS_AF_LO);
  assign sel_afhi  = bus_addr == AW'(OFS_AF_HI);
  assign sel_sec   = bus_addr == AW'(OFS_SEC);

  logic [AF_LO_W-1:0] af_lo;
  logic [AF_HI_W-1:0] af_hi;
  logic [NPINS-1:0]   sec_q;
  logic [NPINS-1:0]   in_q;

  gpio_cfg_word #(.W(FW2), .RST_VAL({FW2{PM_ANALOG[0]}})) u_mode (
    .clk(clk), .rst_n(rst_n), .we(bus_wr_en && sel_mode),
    .wdata(bus_wdata[FW2-1:0]), .q(pad_mode));

  gpio_cfg_word #(.W(NPINS)) u_drv (
    .clk(clk), .rst_n(rst_n), .we(bus_wr_en && sel_drv),
    .wdata(bus_wdata[NPINS-1:0]), .q(pad_od_en));

  gpio_cfg_word #(.W(FW2)) u_speed (
    .clk(clk), .rst_n(rst_n), .we(bus_wr_en && sel_speed),
    .wdata(bus_wdata[FW2-1:0]), .q(pad_speed));

  gpio_cfg_word #(.W(FW2)) u_pull (
    .clk(clk), .rst_n(rst_n), .we(bus_wr_en && sel_pull),
    .wdata(bus_wdata[FW2-1:0]), .q(pad_pull));

  gpio_cfg_word #(.W(AF_LO_W)) u_aflo (
    .clk(clk), .rst_n(rst_n), .we(bus_wr_en && sel_aflo),
    .wdata(bus_wdata[AF_LO_W-1:0]), .q(af_lo));

  gpio_cfg_word #(.W(AF_HI_W)) u_afhi (
    .clk(clk), .rst_n(rst_n), .we(bus_wr_en && sel_afhi),
    .wdata(bus_wdata[AF_HI_W-1:0]), .q(af_hi));

  gpio_cfg_word #(.W(NPINS)) u_sec (
    .clk(clk), .rst_n(rst_n), .we(bus_wr_en && sel_sec),
    .wdata(bus_wdata[NPINS-1:0]), .q(sec_q));

  gpio_out_data #(.NPINS(NPINS), .DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n),
    .we_word(bus_wr_en && sel_out), .we_setcl(bus_wr_en && sel_setcl),
    .wdata(bus_wdata), .level(pad_out));

  gpio_in_sync #(.W(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pad_in), .dout(in_q));

  // per-pin alternate-function index: low word for the first DW/4 pins, high word for the rest
  for (genvar p = 0; p < NPINS; p++) begin : g_af
    if (4 * p < AF_LO_W) begin : g_lo
      assign pad_afsel[4*p +: 4] = af_lo[4*p +: 4];
    end else begin : g_hi
      assign pad_afsel[4*p +: 4] = af_hi[4*p - AF_LO_W +: 4];
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (1'b1)
      sel_mode:  bus_rdata[FW2-1:0]     = pad_mode;
      sel_drv:   bus_rdata[NPINS-1:0]   = pad_od_en;
      sel_speed: bus_rdata[FW2-1:0]     = pad_speed;
      sel_pull:  bus_rdata[FW2-1:0]     = pad_pull;
      sel_in:    bus_rdata[NPINS-1:0]   = in_q;
      sel_out:   bus_rdata[NPINS-1:0]   = pad_out;
      sel_aflo:  bus_rdata[AF_LO_W-1:0] = af_lo;
      sel_afhi:  bus_rdata[AF_HI_W-1:0] = af_hi;
      sel_sec:   bus_rdata[NPINS-1:0]   = sec_q;
      default:   bus_rdata = '0;
    endcase
  end

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_en && sel_mode) |=> $stable(pad_mode));

  assert_mode_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && sel_mode) |=> (pad_mode == $past(bus_wdata[FW2-1:0])));

  assert_af_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr_en && (sel_aflo || sel_afhi)) |=> $stable(pad_afsel));

  assert_setcl_only_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_en && sel_setcl) |=> ($stable(pad_mode) && $stable(pad_od_en) &&
                                  $stable(pad_pull) && $stable(pad_speed) &&
                                  $stable(pad_afsel)));

endmodule

// File: tb/gpio_port_regs_tb.sv
module gpio_port_regs_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr_en = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] pad_in = '0;
  logic [31:0] pad_mode, pad_pull, pad_speed;
  logic [15:0] pad_out, pad_od_en;
  logic [63:0] pad_afsel;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gpio_port_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_mode(pad_mode), .pad_out(pad_out), .pad_od_en(pad_od_en),
    .pad_pull(pad_pull), .pad_speed(pad_speed), .pad_afsel(pad_afsel));

  // bench model of every word
  logic [31:0] m_mode, m_speed, m_pull, m_aflo, m_afhi;
  logic [15:0] m_drv, m_out, m_sec, m_in;

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return m_mode;
      8'h04: return {16'h0, m_drv};
      8'h08: return m_speed;
      8'h0C: return m_pull;
      8'h10: return {16'h0, m_in};
      8'h14: return {16'h0, m_out};
      8'h20: return m_aflo;
      8'h24: return m_afhi;
      8'h30: return {16'h0, m_sec};
      default: return 32'h0;
    endcase
  endfunction

  function automatic void model_write(input logic [7:0] a, input logic [31:0] d);
    case (a)
      8'h00: m_mode  = d;
      8'h04: m_drv   = d[15:0];
      8'h08: m_speed = d;
      8'h0C: m_pull  = d;
      8'h14: m_out   = d[15:0];
      8'h18: m_out   = (m_out & ~d[31:16]) | d[15:0];
      8'h20: m_aflo  = d;
      8'h24: m_afhi  = d;
      8'h30: m_sec   = d[15:0];
      default: ;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(posedge clk);
    #1 bus_wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    @(negedge clk);
    bus_addr = a;
    #1 chk(tag, {32'h0, bus_rdata}, {32'h0, exp_read(a)});
  endtask

  task automatic chk_pads(input string tag);
    chk({tag, " mode R2"},  {32'h0, pad_mode},  {32'h0, m_mode});
    chk({tag, " speed R2"}, {32'h0, pad_speed}, {32'h0, m_speed});
    chk({tag, " pull R2"},  {32'h0, pad_pull},  {32'h0, m_pull});
    chk({tag, " drv R3"},   {48'h0, pad_od_en}, {48'h0, m_drv});
    chk({tag, " af R4"},    pad_afsel,          {m_afhi, m_aflo});
    chk({tag, " out R7"},   {48'h0, pad_out},   {48'h0, m_out});
  endtask

  task automatic rd_all(input string tag);
    rd({tag, " R2 mode"}, 8'h00);
    rd({tag, " R3 drv"}, 8'h04);
    rd({tag, " R2 speed"}, 8'h08);
    rd({tag, " R2 pull"}, 8'h0C);
    rd({tag, " R8 in"}, 8'h10);
    rd({tag, " R7 out"}, 8'h14);
    rd({tag, " R6 setcl"}, 8'h18);
    rd({tag, " R4 aflo"}, 8'h20);
    rd({tag, " R4 afhi"}, 8'h24);
    rd({tag, " R9 sec"}, 8'h30);
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ofs [0:14];
    void'($urandom(32'h5EED_1234));
    ofs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20,
            8'h24, 8'h30, 8'h1C, 8'h28, 8'h2C, 8'h34, 8'hFC};
    m_mode = 32'hFFFF_FFFF; m_speed = '0; m_pull = '0; m_aflo = '0; m_afhi = '0;
    m_drv = '0; m_out = '0; m_sec = '0; m_in = '0;

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset values
    @(negedge clk);
    chk_pads("R1 reset");
    rd_all("R1 reset");

    // R11 / R2: pad outputs change right after the write edge
    @(negedge clk);
    bus_addr = 8'h00; bus_wdata = 32'h1B1B_E4E4; bus_wr_en = 1'b1;
    #1 chk("R11 before edge", {32'h0, pad_mode}, 64'hFFFF_FFFF);
    @(posedge clk);
    #1 bus_wr_en = 1'b0;
    model_write(8'h00, 32'h1B1B_E4E4);
    chk("R11 after edge", {32'h0, pad_mode}, {32'h0, m_mode});

    // R4: split of alternate-function indices at pin 8
    wr(8'h20, 32'h7654_3210);
    wr(8'h24, 32'hFEDC_BA98);
    @(negedge clk);
    chk("R4 pin0 af", {60'h0, pad_afsel[3:0]}, 64'h0);
    chk("R4 pin7 af", {60'h0, pad_afsel[31:28]}, 64'h7);
    chk("R4 pin8 af", {60'h0, pad_afsel[35:32]}, 64'h8);
    chk("R4 pin15 af", {60'h0, pad_afsel[63:60]}, 64'hF);

    // R5: set/clear word behaviour, directed
    wr(8'h14, 32'hFFFF_00F0);
    @(negedge clk);
    chk("R7 direct upper ignored", {48'h0, pad_out}, 64'h00F0);
    wr(8'h18, 32'h0030_0003);           // set 0,1 ; clear 4,5
    @(negedge clk);
    chk("R5 set and clear", {48'h0, pad_out}, 64'h00C3);
    wr(8'h18, 32'h8001_8001);           // pins 0 and 15 both set and cleared
    @(negedge clk);
    chk("R5 both bits set wins", {48'h0, pad_out}, 64'h80C3);
    wr(8'h18, 32'h0000_0000);
    @(negedge clk);
    chk("R5 empty write holds", {48'h0, pad_out}, 64'h80C3);
    rd("R6 setcl reads zero", 8'h18);
    chk_pads("R6 only output changed");

    // R8: two-edge synchronizer, writes ignored
    @(negedge clk);
    pad_in = 16'hA5C3;
    @(posedge clk);
    @(negedge clk);
    bus_addr = 8'h10;
    #1 chk("R8 one edge still old", {32'h0, bus_rdata}, 64'h0);
    @(posedge clk);
    @(negedge clk);
    m_in = 16'hA5C3;
    #1 chk("R8 two edges new", {32'h0, bus_rdata}, {48'h0, m_in});
    wr(8'h10, 32'hFFFF_FFFF);
    rd("R8 write ignored", 8'h10);
    chk_pads("R8 write no pad change");

    // R10: unmapped offsets
    wr(8'h1C, 32'hDEAD_BEEF);
    wr(8'h2C, 32'hFFFF_FFFF);
    wr(8'hFC, 32'h1234_5678);
    rd("R10 unmapped 1C", 8'h1C);
    rd("R10 unmapped 34", 8'h34);
    chk_pads("R10 no pad change");
    rd_all("R10 no reg change");

    // R9 / R3: upper halves read zero
    wr(8'h30, 32'hFFFF_5A5A);
    rd("R9 secure", 8'h30);
    wr(8'h04, 32'hFFFF_0F0F);
    rd("R3 drv", 8'h04);

    // random traffic against the model
    for (int i = 0; i < 300; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      a = ofs[$urandom_range(14, 0)];
      d = $urandom();
      wr(a, d);
      rd("R2 R5 R7 R9 random readback", a);
      if (i % 10 == 0) begin
        @(negedge clk);
        chk_pads("R11 random");
        rd_all("R10 random");
      end
    end

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule